// File: doc/BRIEF.md
# Endpoint Handshake and Stall Responder

This block decides how one endpoint answers each token the packet decoder hands it. It looks at the token kind, whether a control transfer is in its status stage, the endpoint's transfer type and its enable bit. From these it produces a response code one clock later: no reply, NAK, ACK, a zero-length data packet, STALL, or a data packet. It also keeps the DATA0/DATA1 toggle that the transmitter and the receive checker use for that endpoint.

Firmware reaches the block through one control byte. Bit 1 arms the status stage; while it is clear the host is made to wait with NAK. The block disarms the bit by itself once the status stage has been answered or when a new SETUP arrives. Bit 0 stalls the endpoint. Stalling deliberately leaves the data toggle alone. The only way to restart the toggle is to drop and raise the endpoint enable.

Top module: `ep_handshake_resp`

## Requirements
- R1: After reset `rsp_code` is 0 (no reply), `data_pid` is 0 (DATA0), and `stat_armed` and `stall_flag` are 0.
- R2: Token codes on `tok_kind` are 0 none, 1 OUT, 2 IN, 3 SETUP. Transfer codes on `ep_xfer` are 0 control, 1 isochronous, 2 bulk, 3 interrupt. Response codes on `rsp_code` are 0 none, 1 NAK, 2 ACK, 3 zero-length data, 4 STALL, 5 data. The response to a token appears on the clock edge after the token and lasts one cycle.
- R3: For a control endpoint with `status_stage` high and the status bit clear, IN and OUT both get NAK, and the status bit stays clear.
- R4: With the status bit set, a status-stage IN gets zero-length data and a status-stage OUT gets ACK. Either one clears the status bit on the same edge.
- R5: On an enabled, non-isochronous endpoint, SETUP always gets ACK, even when stalled. It clears the status bit and sets `data_pid` to DATA1.
- R6: While the stall bit is set, IN and OUT on an enabled, non-isochronous endpoint get STALL and leave `data_pid` unchanged. After the stall is cleared, the toggle resumes from the value it had.
- R7: An isochronous endpoint ignores the stall bit. IN gets data, OUT and SETUP get no reply, and `data_pid` is held at DATA0.
- R8: Outside the status stage, an OUT is answered with ACK and flips `data_pid`. An IN is answered with data, and `data_pid` flips only when `host_ack` arrives while no token is present, after that data and before the next token. NAK and STALL never flip it.
- R9: While `ep_enable` is low, tokens get no reply and `data_pid` is forced to DATA0. Re-enabling therefore starts from DATA0.
- R10: A write on `cpu_wr` loads the status bit from `cpu_wdata` bit 1 and the stall bit from bit 0. A write in the same cycle as an automatic clear wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_kind | input | 2 | Decoded token of this cycle (0 none, 1 OUT, 2 IN, 3 SETUP) |
| status_stage | input | 1 | Control transfer is in its status stage |
| ep_xfer | input | 2 | Endpoint transfer type |
| ep_enable | input | 1 | Endpoint enable |
| host_ack | input | 1 | Host acknowledged the last data packet |
| cpu_wr | input | 1 | Control byte write strobe |
| cpu_wdata | input | CSR_W | Control byte (bit 1 status arm, bit 0 stall) |
| rsp_code | output | 3 | Response chosen for the previous token |
| data_pid | output | 1 | Current data toggle (0 DATA0, 1 DATA1) |
| stat_armed | output | 1 | Status-stage arm bit |
| stall_flag | output | 1 | Stall bit |

## Verification
A corrupted toggle shows on `data_pid` at the next edge. It also shows the next time data is sent or an OUT is acknowledged, so a toggle that drifts after a STALL or NAK is caught within one token. A status bit that fails to clear, or clears early, shows at once on `stat_armed`. One status-stage token later it also shows as a wrong ZLP/ACK versus NAK. A lost stall bit turns the next IN or OUT response from STALL into data or ACK in the cycle right after that token.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;
    typedef enum logic [1:0] {TOK_NONE = 2'd0, TOK_OUT = 2'd1, TOK_IN = 2'd2, TOK_SETUP = 2'd3} tok_e;
    typedef enum logic [1:0] {XF_CTRL = 2'd0, XF_ISO = 2'd1, XF_BULK = 2'd2, XF_INTR = 2'd3} xfer_e;
    typedef enum logic [2:0] {
        RSP_NONE  = 3'd0,
        RSP_NAK   = 3'd1,
        RSP_ACK   = 3'd2,
        RSP_ZLP   = 3'd3,
        RSP_STALL = 3'd4,
        RSP_DATA  = 3'd5
    } rsp_e;
    localparam int STAT_BIT  = 1;
    localparam int STALL_BIT = 0;
endpackage

// File: rtl/ep_hs_ctrl_bits.sv
module ep_hs_ctrl_bits
    import ep_hs_pkg::*;
#(
    parameter int CSR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic [CSR_W-1:0] cpu_wdata,
    input  logic             auto_clr,
    output logic             stat_q_o,
    output logic             stall_q_o
);
    typedef struct packed {
        logic stat;
        logic stall;
    } bits_t;

    bits_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (auto_clr) begin
            st_d.stat = 1'b0;
        end
        if (cpu_wr) begin
            st_d.stat  = cpu_wdata[STAT_BIT];
            st_d.stall = cpu_wdata[STALL_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_q_o  = st_q.stat;
    assign stall_q_o = st_q.stall;
endmodule

// File: rtl/ep_hs_toggle.sv
module ep_hs_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_zero,
    input  logic force_one,
    input  logic flip,
    output logic tog_q_o
);
    logic tog_d, tog_q;

    always_comb begin
        tog_d = tog_q;
        if (hold_zero) begin
            tog_d = 1'b0;
        end else if (force_one) begin
            tog_d = 1'b1;
        end else if (flip) begin
            tog_d = ~tog_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else begin
            tog_q <= tog_d;
        end
    end

    assign tog_q_o = tog_q;
endmodule

// File: rtl/ep_handshake_resp.sv
module ep_handshake_resp
    import ep_hs_pkg::*;
#(
    parameter int CSR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       tok_kind,
    input  logic             status_stage,
    input  logic [1:0]       ep_xfer,
    input  logic             ep_enable,
    input  logic             host_ack,
    input  logic             cpu_wr,
    input  logic [CSR_W-1:0] cpu_wdata,
    output logic [2:0]       rsp_code,
    output logic             data_pid,
    output logic             stat_armed,
    output logic             stall_flag
);
    typedef struct packed {
        rsp_e code;
        logic pend;
    } resp_t;

    resp_t rs_d, rs_q;
    tok_e  tok;
    xfer_e xf;
    logic  is_iso;
    logic  clr_stat;
    logic  set_one;
    logic  flip;
    logic  stat_q, stall_q, tog_q;

    assign tok    = tok_e'(tok_kind);
    assign xf     = xfer_e'(ep_xfer);
    assign is_iso = (xf == XF_ISO);

    always_comb begin
        rs_d     = rs_q;
        rs_d.code = RSP_NONE;
        clr_stat = 1'b0;
        set_one  = 1'b0;
        flip     = 1'b0;
        if (!ep_enable) begin
            rs_d.pend = 1'b0;
        end else if (tok != TOK_NONE) begin
            rs_d.pend = 1'b0;
            if (is_iso) begin
                rs_d.code = (tok == TOK_IN) ? RSP_DATA : RSP_NONE;
            end else if (tok == TOK_SETUP) begin
                rs_d.code = RSP_ACK;
                clr_stat  = 1'b1;
                set_one   = 1'b1;
            end else if (stall_q) begin
                rs_d.code = RSP_STALL;
            end else if (status_stage && xf == XF_CTRL) begin
                if (!stat_q) begin
                    rs_d.code = RSP_NAK;
                end else begin
                    rs_d.code = (tok == TOK_IN) ? RSP_ZLP : RSP_ACK;
                    clr_stat  = 1'b1;
                end
            end else if (tok == TOK_IN) begin
                rs_d.code = RSP_DATA;
                rs_d.pend = 1'b1;
            end else begin
                rs_d.code = RSP_ACK;
                flip      = 1'b1;
            end
        end else if (host_ack && rs_q.pend) begin
            flip      = 1'b1;
            rs_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q <= '{code: RSP_NONE, pend: 1'b0};
        end else begin
            rs_q <= rs_d;
        end
    end

    ep_hs_ctrl_bits #(.CSR_W(CSR_W)) u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .auto_clr  (clr_stat),
        .stat_q_o  (stat_q),
        .stall_q_o (stall_q)
    );

    ep_hs_toggle u_tog (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_zero (!ep_enable || is_iso),
        .force_one (set_one),
        .flip      (flip),
        .tog_q_o   (tog_q)
    );

    assign rsp_code   = rs_q.code;
    assign data_pid   = tog_q;
    assign stat_armed = stat_q;
    assign stall_flag = stall_q;
endmodule

// File: rtl/ep_handshake_resp_chk.sv
module ep_handshake_resp_chk #(
    parameter int CSR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       tok_kind,
    input logic             status_stage,
    input logic [1:0]       ep_xfer,
    input logic             ep_enable,
    input logic             host_ack,
    input logic             cpu_wr,
    input logic [CSR_W-1:0] cpu_wdata,
    input logic [2:0]       rsp_code,
    input logic             data_pid,
    input logic             stat_armed,
    input logic             stall_flag
);
    p_setup_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_kind == 2'd3 && ep_enable && ep_xfer != 2'd1)
        |=> (rsp_code == 3'd2 && data_pid == 1'b1));

    p_setup_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_kind == 2'd3 && ep_enable && ep_xfer != 2'd1 && !cpu_wr) |=> !stat_armed);

    p_stall_answer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((tok_kind == 2'd1 || tok_kind == 2'd2) && ep_enable && ep_xfer != 2'd1 && stall_flag)
        |=> rsp_code == 3'd4);

    p_no_flip_on_refusal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code == 3'd1 || rsp_code == 3'd4) |-> data_pid == $past(data_pid));

    p_iso_pid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_xfer == 2'd1) |=> data_pid == 1'b0);

    p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_enable |=> (data_pid == 1'b0 && rsp_code == 3'd0));

    p_status_nak_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((tok_kind == 2'd1 || tok_kind == 2'd2) && ep_enable && ep_xfer == 2'd0
         && status_stage && !stall_flag && !stat_armed) |=> rsp_code == 3'd1);

    p_cpu_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |=> (stat_armed == $past(cpu_wdata[1]) && stall_flag == $past(cpu_wdata[0])));
endmodule

bind ep_handshake_resp ep_handshake_resp_chk #(.CSR_W(CSR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tok_kind     (tok_kind),
    .status_stage (status_stage),
    .ep_xfer      (ep_xfer),
    .ep_enable    (ep_enable),
    .host_ack     (host_ack),
    .cpu_wr       (cpu_wr),
    .cpu_wdata    (cpu_wdata),
    .rsp_code     (rsp_code),
    .data_pid     (data_pid),
    .stat_armed   (stat_armed),
    .stall_flag   (stall_flag)
);

// File: tb/ep_handshake_resp_tb.sv
module ep_handshake_resp_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tok_kind = 2'd0;
    logic       status_stage = 1'b0;
    logic [1:0] ep_xfer = 2'd0;
    logic       ep_enable = 1'b1;
    logic       host_ack = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'd0;
    logic [2:0] rsp_code;
    logic       data_pid, stat_armed, stall_flag;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    int m_code = 0, m_tog = 0, m_stat = 0, m_stall = 0, m_pend = 0;

    always #5 clk = ~clk;

    ep_handshake_resp u_dut (
        .clk(clk), .rst_n(rst_n), .tok_kind(tok_kind), .status_stage(status_stage),
        .ep_xfer(ep_xfer), .ep_enable(ep_enable), .host_ack(host_ack),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .rsp_code(rsp_code),
        .data_pid(data_pid), .stat_armed(stat_armed), .stall_flag(stall_flag)
    );

    // Behavioural reference: applied once per rising edge, from inputs held stable.
    task automatic model_edge();
        int code = 0;
        int clr = 0;
        int one = 0;
        int flp = 0;
        int pn = m_pend;
        bit iso = (ep_xfer == 2'd1);
        if (!rst_n) begin
            m_code = 0; m_tog = 0; m_stat = 0; m_stall = 0; m_pend = 0;
            return;
        end
        if (!ep_enable) pn = 0;
        else if (tok_kind != 2'd0) begin
            pn = 0;
            if (iso) code = (tok_kind == 2'd2) ? 5 : 0;
            else if (tok_kind == 2'd3) begin code = 2; clr = 1; one = 1; end
            else if (m_stall != 0) code = 4;
            else if (status_stage && ep_xfer == 2'd0) begin
                if (m_stat == 0) code = 1;
                else begin code = (tok_kind == 2'd2) ? 3 : 2; clr = 1; end
            end else if (tok_kind == 2'd2) begin code = 5; pn = 1; end
            else begin code = 2; flp = 1; end
        end else if (host_ack && m_pend != 0) begin
            flp = 1; pn = 0;
        end
        if (!ep_enable || iso) m_tog = 0;
        else if (one != 0) m_tog = 1;
        else if (flp != 0) m_tog = 1 - m_tog;
        if (cpu_wr) begin m_stat = cpu_wdata[1]; m_stall = cpu_wdata[0]; end
        else if (clr != 0) m_stat = 0;
        m_code = code;
        m_pend = pn;
    endtask

    task automatic compare();
        n_vec++;
        if (int'(rsp_code) != m_code || int'(data_pid) != m_tog ||
            int'(stat_armed) != m_stat || int'(stall_flag) != m_stall) begin
            n_bad++;
            $display("FAIL %s: got code=%0d pid=%0d stat=%0d stall=%0d exp code=%0d pid=%0d stat=%0d stall=%0d",
                     cur_req, rsp_code, data_pid, stat_armed, stall_flag,
                     m_code, m_tog, m_stat, m_stall);
        end
    endtask

    task automatic step(input logic [1:0] tk, input logic ss, input logic ack,
                        input logic wr, input logic [7:0] wd);
        tok_kind = tk; status_stage = ss; host_ack = ack; cpu_wr = wr; cpu_wdata = wd;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        tok_kind = 2'd0; host_ack = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic idle();
        step(2'd0, 1'b0, 1'b0, 1'b0, 8'd0);
    endtask

    initial begin
        cur_req = "R1";
        step(2'd0, 1'b0, 1'b0, 1'b0, 8'd0);
        step(2'd2, 1'b0, 1'b0, 1'b0, 8'd0);
        rst_n = 1'b1;
        idle();

        cur_req = "R10";
        step(2'd0, 1'b0, 1'b0, 1'b1, 8'h03);
        step(2'd0, 1'b0, 1'b0, 1'b1, 8'h00);

        cur_req = "R5";
        ep_xfer = 2'd0;
        step(2'd0, 1'b0, 1'b0, 1'b1, 8'h03);
        step(2'd3, 1'b0, 1'b0, 1'b0, 8'd0);
        step(2'd0, 1'b0, 1'b0, 1'b1, 8'h00);

        cur_req = "R8";
        step(2'd2, 1'b0, 1'b0, 1'b0, 8'd0);
        step(2'd0, 1'b0, 1'b1, 1'b0, 8'd0);
        step(2'd0, 1'b0, 1'b1, 1'b0, 8'd0);
        step(2'd1, 1'b0, 1'b0, 1'b0, 8'd0);
        step(2'd1, 1'b0, 1'b0, 1'b0, 8'd0);
        step(2'd2, 1'b0, 1'b0, 1'b0, 8'd0);
        step(2'd2, 1'b0, 1'b1, 1'b0, 8'd0);

        cur_req = "R3";
        step(2'd2, 1'b1, 1'b0, 1'b0, 8'd0);
        step(2'd1, 1'b1, 1'b0, 1'b0, 8'd0);

        cur_req = "R4";
        step(2'd0, 1'b0, 1'b0, 1'b1, 8'h02);
        step(2'd2, 1'b1, 1'b0, 1'b0, 8'd0);
        step(2'd0, 1'b0, 1'b0, 1'b1, 8'h02);
        step(2'd1, 1'b1, 1'b0, 1'b0, 8'd0);
        step(2'd1, 1'b1, 1'b0, 1'b0, 8'd0);

        cur_req = "R10";
        step(2'd0, 1'b0, 1'b0, 1'b1, 8'h02);
        step(2'd1, 1'b1, 1'b0, 1'b1, 8'h02);

        cur_req = "R6";
        ep_xfer = 2'd2;
        step(2'd1, 1'b0, 1'b0, 1'b0, 8'd0);
        step(2'd0, 1'b0, 1'b0, 1'b1, 8'h01);
        step(2'd2, 1'b0, 1'b0, 1'b0, 8'd0);
        step(2'd1, 1'b0, 1'b0, 1'b0, 8'd0);
        step(2'd0, 1'b0, 1'b1, 1'b0, 8'd0);
        step(2'd3, 1'b0, 1'b0, 1'b0, 8'd0);
        step(2'd1, 1'b0, 1'b0, 1'b0, 8'd0);
        step(2'd0, 1'b0, 1'b0, 1'b1, 8'h00);
        step(2'd1, 1'b0, 1'b0, 1'b0, 8'd0);

        cur_req = "R7";
        step(2'd0, 1'b0, 1'b0, 1'b1, 8'h01);
        ep_xfer = 2'd1;
        step(2'd2, 1'b0, 1'b0, 1'b0, 8'd0);
        step(2'd1, 1'b0, 1'b0, 1'b0, 8'd0);
        step(2'd3, 1'b0, 1'b0, 1'b0, 8'd0);
        step(2'd2, 1'b0, 1'b1, 1'b0, 8'd0);
        step(2'd0, 1'b0, 1'b0, 1'b1, 8'h00);

        cur_req = "R9";
        ep_xfer = 2'd3;
        step(2'd3, 1'b0, 1'b0, 1'b0, 8'd0);
        ep_enable = 1'b0;
        step(2'd1, 1'b0, 1'b0, 1'b0, 8'd0);
        step(2'd2, 1'b0, 1'b0, 1'b0, 8'd0);
        ep_enable = 1'b1;
        step(2'd1, 1'b0, 1'b0, 1'b0, 8'd0);

        cur_req = "R2";
        for (int i = 0; i < 400; i++) begin
            ep_xfer   = 2'($urandom_range(0, 3));
            ep_enable = ($urandom_range(0, 9) != 0);
            step(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0),
                 8'($urandom_range(0, 3)));
        end
        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no completion, expected completion within 20000 cycles");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule